// File: doc/BRIEF.md
# Protocol Header Interpreter and Command Executor

This block sits on the receive side of one serial link channel. It watches the stream of characters coming off the link. Each token is either a data character or an end-of-packet marker. When the channel runs in protocol mode, the block treats the first four data characters of every packet as a header. The header's destination byte is compared with the channel's own address. The low nibble of its control byte is then decoded as a command.

A data command with a matching address opens the path into the receive FIFO for the rest of the packet. A simple control command does not open that path. It is carried out by the execution stage instead, which drives a CPU reset, a group of specific external signals and link reset requests. Any header that is rejected raises a one-cycle error strobe with a cause code. The packet is then dropped up to its end marker.

Three commands are treated as dangerous: asserting the CPU reset, resetting this link and resetting all links. Each of them runs only while a one-shot enable is armed. A dedicated command arms the enable, and the enable disarms itself after one dangerous command has run. In the two bypass modes (transparent, which is the reset mode, and routing) the interpreter does nothing and every token goes straight to the FIFO.

Top module: `proto_header_exec`

## Requirements
- R1: After reset `cpuResetN` is 1, `sesN` is all ones, `safeArmed` is 0, and `fifoWrEn`, `errStrobe`, `linkRstOne` and `linkRstAll` are 0. Capture of the first header begins with the first data character.
- R2: When `mode` is not 2 (0 is transparent, 1 is routing), each data character and each end-of-packet token is written to the FIFO one clock later (`fifoWrEop`=1 for the end marker). No header is decoded and no error or command results.
- R3: When `mode` is 2, the first four data characters of a packet are header bytes in this order: destination address, control byte, transaction ID, spare. None of them is written to the FIFO. When the fourth byte arrives, `hdrCtrl` and `hdrTid` take that header's control and transaction-ID bytes.
- R4: If the destination equals `chanAddr` and the command nibble is 0 (data), the payload characters and the closing end marker are written to the FIFO in arrival order, each one clock after it arrives.
- R5: If the destination does not equal `chanAddr`, `errCause` is 0 and the packet is dropped. This check wins over every other header check.
- R6: Command nibbles 8 to 15 are invalid. They give `errCause` 1, and the packet is dropped with no action taken.
- R7: Command 7 sets `safeArmed`. A dangerous command (1, 5 or 6) that is accepted while armed runs and clears `safeArmed`.
- R8: A dangerous command that arrives while `safeArmed` is 0 gives `errCause` 2 and has no effect.
- R9: Command 1 drives `cpuResetN` to 0 and command 2 drives it to 1. The level holds between commands.
- R10: Command 3 drives low each `sesN` bit whose mask bit is 1, and command 4 drives those bits high. The mask is control-byte bits 7:4, with bit 4 belonging to `sesN[0]`. Unmasked bits are unchanged.
- R11: Command 5 pulses `linkRstOne` and command 6 pulses `linkRstAll`, each for one clock.
- R12: An end marker after one to three header bytes gives `errCause` 3. An end marker with no header bytes gives no error. In both cases the next packet's header is captured from scratch.
- R13: Every rejected header or short packet gives exactly one one-clock `errStrobe` pulse. It is registered on the clock that takes the deciding token.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| mode | input | 2 | 0 transparent, 1 routing, 2 protocol |
| chanAddr | input | CHAR_W | Address of this channel |
| rxValid | input | 1 | A token is present this clock |
| rxIsEop | input | 1 | The token is an end-of-packet marker |
| rxData | input | CHAR_W | Data character |
| fifoWrEn | output | 1 | Receive FIFO write strobe |
| fifoWrData | output | CHAR_W | Character written to the FIFO |
| fifoWrEop | output | 1 | The write is an end marker |
| errStrobe | output | 1 | One-clock error pulse |
| errCause | output | 2 | 0 address, 1 command, 2 not armed, 3 short header |
| hdrTid | output | CHAR_W | Transaction ID of the last complete header |
| hdrCtrl | output | CHAR_W | Control byte of the last complete header |
| cpuResetN | output | 1 | CPU reset level, active low |
| sesN | output | SES_N | Specific external signal levels, active low |
| linkRstOne | output | 1 | Reset-this-link pulse |
| linkRstAll | output | 1 | Reset-all-links pulse |
| safeArmed | output | 1 | One-shot enable for dangerous commands |

## Verification
The bench builds the block with its default parameters: 8-bit characters, a four-byte header and four external signals. With these values every one of the sixteen command nibbles can be written, and each mask bit in the control byte maps onto one `sesN` bit, so set and clear patterns on disjoint and overlapping bits are all reachable. Because the header is only four bytes, short packets of one, two and three characters can be driven, as well as empty packets. Dangerous commands are sent both with and without the enable armed.

// File: rtl/phi_pkg.sv
package phi_pkg;

  localparam logic [1:0] MODE_PROTOCOL = 2'd2;

  localparam logic [3:0] CMD_DATA      = 4'd0;
  localparam logic [3:0] CMD_CPU_ON    = 4'd1;
  localparam logic [3:0] CMD_CPU_OFF   = 4'd2;
  localparam logic [3:0] CMD_SES_ON    = 4'd3;
  localparam logic [3:0] CMD_SES_OFF   = 4'd4;
  localparam logic [3:0] CMD_LINK_ONE  = 4'd5;
  localparam logic [3:0] CMD_LINK_ALL  = 4'd6;
  localparam logic [3:0] CMD_ARM       = 4'd7;

  localparam logic [1:0] ERR_ADDR  = 2'd0;
  localparam logic [1:0] ERR_CMD   = 2'd1;
  localparam logic [1:0] ERR_SAFE  = 2'd2;
  localparam logic [1:0] ERR_SHORT = 2'd3;

  // control -> datapath strobes
  typedef struct packed {
    logic hdrTake;
    logic hdrClear;
    logic fwdData;
    logic fwdEop;
  } dpStrobe_t;

endpackage

// File: rtl/phi_datapath.sv
module phi_datapath
  import phi_pkg::*;
#(
  parameter int CHAR_W    = 8,
  parameter int HDR_BYTES = 4,
  localparam int CNT_W    = $clog2(HDR_BYTES)
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobe,
  input  logic [CHAR_W-1:0] rxData,
  output logic [CNT_W-1:0]  hdrCnt,
  output logic [CHAR_W-1:0] hdrAddrWork,
  output logic [CHAR_W-1:0] hdrCtrlWork,
  output logic [CHAR_W-1:0] hdrTid,
  output logic [CHAR_W-1:0] hdrCtrl,
  output logic              fifoWrEn,
  output logic [CHAR_W-1:0] fifoWrData,
  output logic              fifoWrEop
);

  localparam logic [CNT_W-1:0] LAST_POS = CNT_W'(HDR_BYTES - 1);

  logic [CHAR_W-1:0] tidWork;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      hdrCnt      <= '0;
      hdrAddrWork <= '0;
      hdrCtrlWork <= '0;
      tidWork     <= '0;
      hdrTid      <= '0;
      hdrCtrl     <= '0;
    end else if (strobe.hdrClear) begin
      hdrCnt <= '0;
    end else if (strobe.hdrTake) begin
      hdrCnt <= (hdrCnt == LAST_POS) ? '0 : hdrCnt + 1'b1;
      case (hdrCnt)
        CNT_W'(0): hdrAddrWork <= rxData;
        CNT_W'(1): hdrCtrlWork <= rxData;
        CNT_W'(2): tidWork     <= rxData;
        default:   ;
      endcase
      if (hdrCnt == LAST_POS) begin
        hdrTid  <= tidWork;
        hdrCtrl <= hdrCtrlWork;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      fifoWrEn   <= 1'b0;
      fifoWrData <= '0;
      fifoWrEop  <= 1'b0;
    end else begin
      fifoWrEn   <= strobe.fwdData | strobe.fwdEop;
      fifoWrData <= strobe.fwdData ? rxData : '0;
      fifoWrEop  <= strobe.fwdEop;
    end
  end

  // header bytes never reach the FIFO
  assert_hdr_silent_R3: assert property (@(posedge clk) disable iff (!rstN)
    strobe.hdrTake |=> !fifoWrEn);

endmodule

// File: rtl/phi_control.sv
module phi_control
  import phi_pkg::*;
#(
  parameter int CHAR_W    = 8,
  parameter int HDR_BYTES = 4,
  parameter int SES_N     = 4,
  localparam int CNT_W    = $clog2(HDR_BYTES)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        mode,
  input  logic [CHAR_W-1:0] chanAddr,
  input  logic              rxValid,
  input  logic              rxIsEop,
  input  logic [CNT_W-1:0]  hdrCnt,
  input  logic [CHAR_W-1:0] hdrAddrWork,
  input  logic [CHAR_W-1:0] hdrCtrlWork,
  output dpStrobe_t         strobe,
  output logic              errStrobe,
  output logic [1:0]        errCause,
  output logic              cpuResetN,
  output logic [SES_N-1:0]  sesN,
  output logic              linkRstOne,
  output logic              linkRstAll,
  output logic              safeArmed
);

  localparam logic [CNT_W-1:0] LAST_POS = CNT_W'(HDR_BYTES - 1);

  typedef enum logic [1:0] {ST_HDR, ST_PASS, ST_DROP} rxState_e;
  rxState_e state, stateNext;

  logic              isProto, dataTok, eopTok;
  logic              addrOk, cmdValid, dangerCmd;
  logic [3:0]        cmd;
  logic [SES_N-1:0]  sesMask;
  logic              doErr, doExec;
  logic [1:0]        causeNext;

  assign isProto   = (mode == MODE_PROTOCOL);
  assign dataTok   = rxValid & ~rxIsEop;
  assign eopTok    = rxValid & rxIsEop;
  assign cmd       = hdrCtrlWork[3:0];
  assign sesMask   = hdrCtrlWork[4 +: SES_N];
  assign addrOk    = (hdrAddrWork == chanAddr);
  assign cmdValid  = ~cmd[3];
  assign dangerCmd = (cmd == CMD_CPU_ON) || (cmd == CMD_LINK_ONE) || (cmd == CMD_LINK_ALL);

  always_comb begin
    strobe    = '0;
    stateNext = state;
    doErr     = 1'b0;
    doExec    = 1'b0;
    causeNext = ERR_ADDR;
    if (!isProto) begin
      strobe.hdrClear = 1'b1;
      strobe.fwdData  = dataTok;
      strobe.fwdEop   = eopTok;
      stateNext       = ST_HDR;
    end else begin
      unique case (state)
        ST_HDR: begin
          if (dataTok) begin
            strobe.hdrTake = 1'b1;
            if (hdrCnt == LAST_POS) begin
              stateNext = ST_DROP;
              if (!addrOk) begin
                doErr = 1'b1; causeNext = ERR_ADDR;
              end else if (!cmdValid) begin
                doErr = 1'b1; causeNext = ERR_CMD;
              end else if (dangerCmd && !safeArmed) begin
                doErr = 1'b1; causeNext = ERR_SAFE;
              end else begin
                doExec = 1'b1;
                if (cmd == CMD_DATA) stateNext = ST_PASS;
              end
            end
          end else if (eopTok) begin
            strobe.hdrClear = 1'b1;
            if (hdrCnt != '0) begin
              doErr = 1'b1; causeNext = ERR_SHORT;
            end
          end
        end
        ST_PASS: begin
          strobe.fwdData = dataTok;
          if (eopTok) begin
            strobe.fwdEop   = 1'b1;
            strobe.hdrClear = 1'b1;
            stateNext       = ST_HDR;
          end
        end
        default: begin
          if (eopTok) begin
            strobe.hdrClear = 1'b1;
            stateNext       = ST_HDR;
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state      <= ST_HDR;
      errStrobe  <= 1'b0;
      errCause   <= ERR_ADDR;
      linkRstOne <= 1'b0;
      linkRstAll <= 1'b0;
      cpuResetN  <= 1'b1;
      sesN       <= '1;
      safeArmed  <= 1'b0;
    end else begin
      state      <= stateNext;
      errStrobe  <= doErr;
      if (doErr) errCause <= causeNext;
      linkRstOne <= doExec && (cmd == CMD_LINK_ONE);
      linkRstAll <= doExec && (cmd == CMD_LINK_ALL);
      if (doExec) begin
        case (cmd)
          CMD_CPU_ON:  cpuResetN <= 1'b0;
          CMD_CPU_OFF: cpuResetN <= 1'b1;
          CMD_SES_ON:  sesN      <= sesN & ~sesMask;
          CMD_SES_OFF: sesN      <= sesN | sesMask;
          CMD_ARM:     safeArmed <= 1'b1;
          default:     ;
        endcase
        if (dangerCmd) safeArmed <= 1'b0;
      end
    end
  end

  assert_bypass_quiet_R2: assert property (@(posedge clk) disable iff (!rstN)
    $past(mode != MODE_PROTOCOL) |-> !errStrobe && !linkRstOne && !linkRstAll);
  assert_disarm_after_use_R7: assert property (@(posedge clk) disable iff (!rstN)
    $fell(cpuResetN) |-> !safeArmed);
  assert_armed_before_use_R8: assert property (@(posedge clk) disable iff (!rstN)
    $fell(cpuResetN) |-> $past(safeArmed));
  assert_link_pulse_R11: assert property (@(posedge clk) disable iff (!rstN)
    (linkRstOne || linkRstAll) |=> !(linkRstOne || linkRstAll));
  assert_err_pulse_R13: assert property (@(posedge clk) disable iff (!rstN)
    errStrobe |=> !errStrobe);
  assert_one_event_R13: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({errStrobe, linkRstOne, linkRstAll}));

endmodule

// File: rtl/proto_header_exec.sv
module proto_header_exec
  import phi_pkg::*;
#(
  parameter int CHAR_W    = 8,
  parameter int HDR_BYTES = 4,
  parameter int SES_N     = 4,
  localparam int CNT_W    = $clog2(HDR_BYTES)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        mode,
  input  logic [CHAR_W-1:0] chanAddr,
  input  logic              rxValid,
  input  logic              rxIsEop,
  input  logic [CHAR_W-1:0] rxData,
  output logic              fifoWrEn,
  output logic [CHAR_W-1:0] fifoWrData,
  output logic              fifoWrEop,
  output logic              errStrobe,
  output logic [1:0]        errCause,
  output logic [CHAR_W-1:0] hdrTid,
  output logic [CHAR_W-1:0] hdrCtrl,
  output logic              cpuResetN,
  output logic [SES_N-1:0]  sesN,
  output logic              linkRstOne,
  output logic              linkRstAll,
  output logic              safeArmed
);

  dpStrobe_t         strobe;
  logic [CNT_W-1:0]  hdrCnt;
  logic [CHAR_W-1:0] hdrAddrWork;
  logic [CHAR_W-1:0] hdrCtrlWork;

  phi_control #(.CHAR_W(CHAR_W), .HDR_BYTES(HDR_BYTES), .SES_N(SES_N)) i_control (
    .clk(clk), .rstN(rstN), .mode(mode), .chanAddr(chanAddr),
    .rxValid(rxValid), .rxIsEop(rxIsEop), .hdrCnt(hdrCnt),
    .hdrAddrWork(hdrAddrWork), .hdrCtrlWork(hdrCtrlWork), .strobe(strobe),
    .errStrobe(errStrobe), .errCause(errCause), .cpuResetN(cpuResetN),
    .sesN(sesN), .linkRstOne(linkRstOne), .linkRstAll(linkRstAll),
    .safeArmed(safeArmed)
  );

  phi_datapath #(.CHAR_W(CHAR_W), .HDR_BYTES(HDR_BYTES)) i_datapath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .rxData(rxData),
    .hdrCnt(hdrCnt), .hdrAddrWork(hdrAddrWork), .hdrCtrlWork(hdrCtrlWork),
    .hdrTid(hdrTid), .hdrCtrl(hdrCtrl), .fifoWrEn(fifoWrEn),
    .fifoWrData(fifoWrData), .fifoWrEop(fifoWrEop)
  );

endmodule

// File: tb/test_proto_header_exec.sv
module test_proto_header_exec;

  logic       clk = 1'b0;
  logic       rstN;
  logic [1:0] mode;
  logic [7:0] chanAddr;
  logic       rxValid, rxIsEop;
  logic [7:0] rxData;
  logic       fifoWrEn, fifoWrEop, errStrobe, cpuResetN, linkRstOne, linkRstAll, safeArmed;
  logic [7:0] fifoWrData, hdrTid, hdrCtrl;
  logic [1:0] errCause;
  logic [3:0] sesN;

  proto_header_exec i_proto_header_exec (
    .clk(clk), .rstN(rstN), .mode(mode), .chanAddr(chanAddr),
    .rxValid(rxValid), .rxIsEop(rxIsEop), .rxData(rxData),
    .fifoWrEn(fifoWrEn), .fifoWrData(fifoWrData), .fifoWrEop(fifoWrEop),
    .errStrobe(errStrobe), .errCause(errCause), .hdrTid(hdrTid), .hdrCtrl(hdrCtrl),
    .cpuResetN(cpuResetN), .sesN(sesN), .linkRstOne(linkRstOne),
    .linkRstAll(linkRstAll), .safeArmed(safeArmed)
  );

  always #5 clk = ~clk;

  int total = 0;
  int bad = 0;
  int fifoCnt, eopCnt, errCnt, oneCnt, allCnt;
  int lastCause;
  logic [7:0] fifoLog [16];

  task automatic check(input string req, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic clearCounts();
    fifoCnt = 0; eopCnt = 0; errCnt = 0; oneCnt = 0; allCnt = 0; lastCause = -1;
  endtask

  // drive one token at a falling edge, sample its registered result one clock later
  task automatic tok(input bit eop, input logic [7:0] d);
    rxValid = 1'b1; rxIsEop = eop; rxData = d;
    @(negedge clk);
    if (fifoWrEn) begin
      if (fifoCnt < 16) fifoLog[fifoCnt] = fifoWrData;
      fifoCnt++;
      if (fifoWrEop) eopCnt++;
    end
    if (errStrobe) begin errCnt++; lastCause = int'(errCause); end
    if (linkRstOne) oneCnt++;
    if (linkRstAll) allCnt++;
    rxValid = 1'b0; rxIsEop = 1'b0; rxData = '0;
  endtask

  task automatic sendPkt(input logic [7:0] addr, input logic [7:0] ctrl, input logic [7:0] tid,
                         input int n, input logic [7:0] base);
    tok(0, addr); tok(0, ctrl); tok(0, tid); tok(0, 8'hEE);
    for (int i = 0; i < n; i++) tok(0, base + 8'(i));
    tok(1, 8'h00);
  endtask

  task automatic testReset();
    check("R1", "cpuResetN", cpuResetN, 1);
    check("R1", "sesN", sesN, 4'hF);
    check("R1", "safeArmed", safeArmed, 0);
    check("R1", "quiet outputs", {fifoWrEn, errStrobe, linkRstOne, linkRstAll}, 0);
  endtask

  task automatic testBypass();
    mode = 2'd0; clearCounts();
    sendPkt(8'h77, 8'h01, 8'h00, 2, 8'hA0);
    check("R2", "transparent writes", fifoCnt, 7);
    check("R2", "transparent first char", fifoLog[0], 8'h77);
    check("R2", "transparent eop", eopCnt, 1);
    check("R2", "no cpu reset", cpuResetN, 1);
    mode = 2'd1; clearCounts();
    tok(0, 8'h31); tok(1, 8'h00);
    check("R2", "routing writes", fifoCnt, 2);
    check("R2", "routing data", fifoLog[0], 8'h31);
    check("R2", "no errors", errCnt, 0);
  endtask

  task automatic testData();
    mode = 2'd2; clearCounts();
    sendPkt(8'h5A, 8'hC0, 8'h33, 3, 8'h10);
    check("R4", "payload writes", fifoCnt, 4);
    check("R4", "payload order", {fifoLog[0], fifoLog[1], fifoLog[2]}, 24'h101112);
    check("R4", "closing eop", eopCnt, 1);
    check("R3", "tid captured", hdrTid, 8'h33);
    check("R3", "ctrl captured", hdrCtrl, 8'hC0);
    check("R3", "no error", errCnt, 0);
  endtask

  task automatic testMismatch();
    clearCounts();
    sendPkt(8'h5B, 8'h00, 8'h01, 2, 8'h40);
    check("R5", "mismatch dropped", fifoCnt, 0);
    check("R5", "mismatch cause", lastCause, 0);
    check("R13", "single pulse", errCnt, 1);
    clearCounts();
    sendPkt(8'h11, 8'h0F, 8'h02, 0, 8'h00);
    check("R5", "address wins over bad cmd", lastCause, 0);
  endtask

  task automatic testBadCmd();
    clearCounts();
    sendPkt(8'h5A, 8'h0B, 8'h44, 2, 8'h50);
    check("R6", "invalid cause", lastCause, 1);
    check("R6", "invalid dropped", fifoCnt, 0);
    check("R6", "no action", {cpuResetN, sesN}, 5'h1F);
    check("R3", "ctrl of last header", hdrCtrl, 8'h0B);
  endtask

  task automatic testSafety();
    clearCounts();
    sendPkt(8'h5A, 8'h01, 8'h00, 0, 8'h00);
    check("R8", "unarmed cause", lastCause, 2);
    check("R8", "cpu reset untouched", cpuResetN, 1);
    clearCounts();
    sendPkt(8'h5A, 8'h07, 8'h00, 0, 8'h00);
    check("R7", "armed", safeArmed, 1);
    check("R7", "arm no error", errCnt, 0);
    sendPkt(8'h5A, 8'h01, 8'h00, 2, 8'h60);
    check("R9", "cpu reset asserted", cpuResetN, 0);
    check("R7", "disarmed after use", safeArmed, 0);
    check("R7", "command payload dropped", fifoCnt, 0);
    sendPkt(8'h5A, 8'h00, 8'h00, 0, 8'h00);
    check("R9", "cpu reset holds", cpuResetN, 0);
    sendPkt(8'h5A, 8'h02, 8'h00, 0, 8'h00);
    check("R9", "cpu reset released", cpuResetN, 1);
    clearCounts();
    sendPkt(8'h5A, 8'h01, 8'h00, 0, 8'h00);
    check("R8", "second use refused", lastCause, 2);
    check("R8", "still released", cpuResetN, 1);
  endtask

  task automatic testSes();
    sendPkt(8'h5A, 8'h53, 8'h00, 0, 8'h00);
    check("R10", "set mask 5", sesN, 4'hA);
    sendPkt(8'h5A, 8'h33, 8'h00, 0, 8'h00);
    check("R10", "set overlapping mask", sesN, 4'h8);
    sendPkt(8'h5A, 8'h14, 8'h00, 0, 8'h00);
    check("R10", "clear bit 0", sesN, 4'h9);
  endtask

  task automatic testLink();
    clearCounts();
    sendPkt(8'h5A, 8'h07, 8'h00, 0, 8'h00);
    sendPkt(8'h5A, 8'h05, 8'h00, 0, 8'h00);
    check("R11", "one-link pulses", oneCnt, 1);
    check("R11", "all-link none", allCnt, 0);
    check("R7", "disarmed by link reset", safeArmed, 0);
    sendPkt(8'h5A, 8'h07, 8'h00, 0, 8'h00);
    sendPkt(8'h5A, 8'h06, 8'h00, 0, 8'h00);
    check("R11", "all-link pulses", allCnt, 1);
    check("R11", "one-link unchanged", oneCnt, 1);
  endtask

  task automatic testShort();
    clearCounts();
    tok(0, 8'h5A); tok(0, 8'h00); tok(1, 8'h00);
    check("R12", "short cause", lastCause, 3);
    check("R12", "short one pulse", errCnt, 1);
    clearCounts();
    tok(1, 8'h00);
    check("R12", "empty packet silent", errCnt, 0);
    tok(0, 8'h5A); tok(0, 8'h00); tok(0, 8'h00); tok(1, 8'h00);
    check("R12", "three-byte short", lastCause, 3);
    clearCounts();
    sendPkt(8'h5A, 8'h00, 8'h99, 1, 8'h7E);
    check("R12", "fresh header after short", fifoCnt, 2);
    check("R12", "fresh payload", fifoLog[0], 8'h7E);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rstN = 1'b0; mode = 2'd0; chanAddr = 8'h5A;
    rxValid = 1'b0; rxIsEop = 1'b0; rxData = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testBypass();
    testData();
    testMismatch();
    testBadCmd();
    testSafety();
    testSes();
    testLink();
    testShort();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule